// File: doc/BRIEF.md
# Widening SIMD Lane Adder

This block adds a 64-bit vector of narrow lanes to a 128-bit vector of lanes twice as wide, lane by lane, and returns a 128-bit vector of wide lanes. A 2-bit size code picks the narrow lane width at run time: 8, 16 or 32 bits. The lane count follows from that width: 8, 4 or 2. Each narrow lane is widened to the width of its partner lane before the add. It is zero-extended in unsigned mode and sign-extended in signed mode. Each sum keeps only the low bits that fit its wide lane.

The block sits in a vector execution pipe and takes one operation per cycle. The caller raises `in_valid` with the operands and the control fields. Exactly one clock later the registered result appears with `out_valid`, or one of two fault flags is raised. The first fault is a size code that has no meaning. The second is a destination or first-source register index that is not even, which means it cannot name a 128-bit register pair. The datapath has the same depth whatever the data values are.

Top module: `wide_lane_adder`

## Requirements
- R1: With size code 00, narrow lane e is `narrow_b[8e +: 8]` and wide lane e is `wide_a[16e +: 16]`, for e = 0..7. Result lane e is `result[16e +: 16]`.
- R2: With size code 01 there are four lanes: `narrow_b[16e +: 16]` is added to `wide_a[32e +: 32]` and the sum lands in `result[32e +: 32]`.
- R3: With size code 10 there are two lanes: `narrow_b[32e +: 32]` is added to `wide_a[64e +: 64]` and the sum lands in `result[64e +: 64]`.
- R4: When `is_unsigned` is 1, each narrow lane is zero-extended before the add. When it is 0, each narrow lane is sign-extended from its top bit.
- R5: Each result lane is the sum modulo 2 to the power of the wide-lane width. No carry passes from one lane into the next, and nothing saturates.
- R6: Size code 11 is reserved. One cycle after such an operation is accepted, `reserved_flag` is 1, `out_valid` is 0 and `result` is all zeros.
- R7: When `dst_idx_lsb` or `src_idx_lsb` is 1, the operation is undefined. One cycle after it is accepted, `undef_flag` is 1, `out_valid` is 0 and `result` is all zeros.
- R8: A legal operation accepted on a rising edge with `in_valid` = 1 shows its result with `out_valid` = 1 after exactly that edge. The latency is one cycle and does not depend on the data.
- R9: When the synchronous active-high `rst` is sampled, `out_valid`, both flags and `result` all clear to 0 on that edge.
- R10: On an edge where `in_valid` is 0, `out_valid` and both flags go to 0 and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| wide_a | input | 128 | Wide-lane operand |
| narrow_b | input | 64 | Narrow-lane operand |
| size_code | input | 2 | Narrow lane width: 00 = 8, 01 = 16, 10 = 32, 11 = reserved |
| is_unsigned | input | 1 | 1 = zero-extend the narrow lanes, 0 = sign-extend them |
| dst_idx_lsb | input | 1 | Bit 0 of the destination register index |
| src_idx_lsb | input | 1 | Bit 0 of the first-source register index |
| out_valid | output | 1 | `result` holds a legal sum |
| result | output | 128 | Wide-lane sums |
| reserved_flag | output | 1 | The accepted operation used size code 11 |
| undef_flag | output | 1 | The accepted operation had an odd register index |

## Verification
On every cycle, the assertions check the control behaviour: the one-cycle latency, the zeroed result and low valid under either fault, the clearing on reset, and the result holding while idle. They also check that a valid result never shows alongside a fault flag. Lane arithmetic cannot be checked by an assertion. Lane placement, sign versus zero extension and wrap without cross-lane carry show only in the bench's scenarios. Those scenarios compare every lane against an independent model for all three widths and both signedness modes. They include lanes of all ones and lanes with only the top bit set.

// File: rtl/wadd_pkg.sv
package wadd_pkg;

    localparam int NARROW_W   = 64;
    localparam int WIDE_W     = 2 * NARROW_W;
    localparam int NUM_SIZES  = 3;

    typedef enum logic [1:0] {
        LANE8     = 2'b00,
        LANE16    = 2'b01,
        LANE32    = 2'b10,
        LANE_RSVD = 2'b11
    } lane_sz_e;

    typedef struct packed {
        lane_sz_e sz;
        logic     uns;
        logic     reserved;
        logic     undef;
        logic     legal;
    } op_ctl_t;

    typedef struct packed {
        logic              valid;
        logic              reserved;
        logic              undef;
        logic [WIDE_W-1:0] data;
    } out_reg_t;

    function automatic int narrow_bits(int sel);
        return 8 << sel;
    endfunction

    function automatic int lane_count(int nw, int sel);
        return nw / narrow_bits(sel);
    endfunction

endpackage

// File: rtl/wadd_lane_add.sv
module wadd_lane_add #(
    parameter int ESIZE = 8,
    localparam int WL   = 2 * ESIZE
) (
    input  logic [WL-1:0]    wide_lane,
    input  logic [ESIZE-1:0] narrow_lane,
    input  logic             uns,
    output logic [WL-1:0]    sum_lane
);
    logic             fill;
    logic [WL-1:0]    ext;

    always_comb begin
        fill     = ~uns & narrow_lane[ESIZE-1];
        ext      = {{ESIZE{fill}}, narrow_lane};
        sum_lane = wide_lane + ext;   // wraps at lane width
    end

endmodule

// File: rtl/wadd_slice.sv
module wadd_slice #(
    parameter int NW    = 64,
    parameter int ESIZE = 8,
    localparam int WW   = 2 * NW,
    localparam int LANES = NW / ESIZE,
    localparam int WL   = 2 * ESIZE
) (
    input  logic [WW-1:0] wide_in,
    input  logic [NW-1:0] narrow_in,
    input  logic          uns,
    output logic [WW-1:0] sum_out
);
    for (genvar e = 0; e < LANES; e++) begin : g_lane
        wadd_lane_add #(.ESIZE(ESIZE)) u_lane (
            .wide_lane   (wide_in[e*WL +: WL]),
            .narrow_lane (narrow_in[e*ESIZE +: ESIZE]),
            .uns         (uns),
            .sum_lane    (sum_out[e*WL +: WL])
        );
    end

endmodule

// File: rtl/wadd_decode.sv
module wadd_decode
    import wadd_pkg::*;
(
    input  logic [1:0] size_code,
    input  logic       is_unsigned,
    input  logic       dst_idx_lsb,
    input  logic       src_idx_lsb,
    output op_ctl_t    ctl
);
    always_comb begin
        ctl.sz       = lane_sz_e'(size_code);
        ctl.uns      = is_unsigned;
        ctl.reserved = (lane_sz_e'(size_code) == LANE_RSVD);
        ctl.undef    = dst_idx_lsb | src_idx_lsb;
        ctl.legal    = ~ctl.reserved & ~ctl.undef;
    end

endmodule

// File: rtl/wide_lane_adder.sv
module wide_lane_adder
    import wadd_pkg::*;
#(
    parameter int NW  = NARROW_W,
    localparam int WW = 2 * NW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [WW-1:0] wide_a,
    input  logic [NW-1:0] narrow_b,
    input  logic [1:0]    size_code,
    input  logic          is_unsigned,
    input  logic          dst_idx_lsb,
    input  logic          src_idx_lsb,
    output logic          out_valid,
    output logic [WW-1:0] result,
    output logic          reserved_flag,
    output logic          undef_flag
);
    op_ctl_t        ctl;
    logic [WW-1:0]  cand [NUM_SIZES];
    logic [WW-1:0]  picked;
    logic [WW-1:0]  data_q;
    logic           valid_q, rsvd_q, undef_q;

    wadd_decode u_dec (
        .size_code   (size_code),
        .is_unsigned (is_unsigned),
        .dst_idx_lsb (dst_idx_lsb),
        .src_idx_lsb (src_idx_lsb),
        .ctl         (ctl)
    );

    // one adder slice per legal narrow width, all evaluated in parallel
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        wadd_slice #(.NW(NW), .ESIZE(narrow_bits(k))) u_slice (
            .wide_in   (wide_a),
            .narrow_in (narrow_b),
            .uns       (ctl.uns),
            .sum_out   (cand[k])
        );
    end

    always_comb begin
        unique case (ctl.sz)
            LANE8:   picked = cand[0];
            LANE16:  picked = cand[1];
            LANE32:  picked = cand[2];
            default: picked = '0;
        endcase
        if (!ctl.legal) picked = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsvd_q  <= 1'b0;
            undef_q <= 1'b0;
            data_q  <= '0;
        end else if (in_valid) begin
            valid_q <= ctl.legal;
            rsvd_q  <= ctl.reserved;
            undef_q <= ctl.undef;
            data_q  <= picked;
        end else begin
            valid_q <= 1'b0;
            rsvd_q  <= 1'b0;
            undef_q <= 1'b0;
        end
    end

    assign out_valid     = valid_q;
    assign result        = data_q;
    assign reserved_flag = rsvd_q;
    assign undef_flag    = undef_q;

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code != 2'b11 && !dst_idx_lsb && !src_idx_lsb) |=> out_valid);

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code == 2'b11) |=> (reserved_flag && !out_valid && result == '0));

    p_undef_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (dst_idx_lsb || src_idx_lsb)) |=> (undef_flag && !out_valid && result == '0));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !reserved_flag && !undef_flag && $stable(result)));

    p_valid_excl_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!reserved_flag && !undef_flag));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && !reserved_flag && !undef_flag && result == '0));

endmodule

// File: tb/sim_wide_lane_adder.sv
module sim_wide_lane_adder;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] wide_a;
    logic [63:0]  narrow_b;
    logic [1:0]   size_code;
    logic         is_unsigned, dst_idx_lsb, src_idx_lsb;
    logic         out_valid, reserved_flag, undef_flag;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wide_lane_adder u0 (.*);

    localparam int NT = 6;
    localparam logic [127:0] TA [NT] = '{
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
        128'h7FFF_0001_8000_FFFF_0000_1234_ABCD_5555,
        128'hFFFF_FFFF_0000_0000_8000_0000_7FFF_FFFF,
        128'h0000_0000_0000_0001_FFFF_FFFF_FFFF_FFFF,
        128'hDEAD_BEEF_CAFE_F00D_1357_9BDF_2468_ACE0,
        128'h8080_8080_7F7F_7F7F_0101_0101_FEFE_FEFE
    };
    localparam logic [63:0] TB [NT] = '{
        64'h8899_AABB_CCDD_EEFF,
        64'h7F80_0180_FF01_8000,
        64'h8000_0000_7FFF_FFFF,
        64'h0000_0001_0000_0001,
        64'h0F1E_2D3C_4B5A_6978,
        64'hFF00_FF00_00FF_00FF
    };
    localparam logic [1:0] TS [NT] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd0};
    localparam bit         TU [NT] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    // Independent lane model from R1..R5
    function automatic logic [127:0] model(logic [127:0] a, logic [63:0] b, int sz, bit uns);
        int es = 8 << sz;
        logic [127:0] m1 = (128'd1 << es) - 1;
        logic [127:0] m2 = (128'd1 << (2 * es)) - 1;
        logic [127:0] r  = '0;
        for (int e = 0; e < 64 / es; e++) begin
            logic [127:0] n, w, s;
            n = ({64'd0, b} >> (e * es)) & m1;
            if (!uns && n[es-1]) n = n | (m2 & ~m1);
            w = (a >> (e * 2 * es)) & m2;
            s = (w + n) & m2;
            r = r | (s << (e * 2 * es));
        end
        return r;
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one operation; returns at the negedge after the capturing edge
    task automatic issue(logic [127:0] a, logic [63:0] b, logic [1:0] sz, bit uns, bit dl, bit sl);
        @(negedge clk);
        wide_a = a; narrow_b = b; size_code = sz; is_unsigned = uns;
        dst_idx_lsb = dl; src_idx_lsb = sl; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic string size_req(int sz);
        return (sz == 0) ? "R1" : (sz == 1) ? "R2" : "R3";
    endfunction

    initial begin
        rst = 1'b1; in_valid = 1'b0; wide_a = '0; narrow_b = '0; size_code = '0;
        is_unsigned = 1'b0; dst_idx_lsb = 1'b0; src_idx_lsb = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset", {out_valid, reserved_flag, undef_flag}, 3'b000);
        chk("R9 reset result", result, '0);
        rst = 1'b0;

        // table walk (R1 R2 R3 R4 R5)
        for (int i = 0; i < NT; i++) begin
            issue(TA[i], TB[i], TS[i], TU[i], 1'b0, 1'b0);
            chk({size_req(TS[i]), " R4 table"}, result, model(TA[i], TB[i], TS[i], TU[i]));
            chk("R8 table valid", out_valid, 1'b1);
        end

        // corners: all ones and lane top bit only, every size and mode
        for (int sz = 0; sz < 3; sz++) begin
            for (int u = 0; u < 2; u++) begin
                logic [127:0] ta;
                logic [63:0]  tb;
                int es = 8 << sz;
                issue('1, '1, 2'(sz), u[0], 1'b0, 1'b0);
                chk({size_req(sz), " R5 all ones"}, result, model('1, '1, sz, u[0]));
                ta = '0; tb = '0;
                for (int e = 0; e < 64 / es; e++) begin
                    tb[e*es + es - 1]       = 1'b1;
                    ta[e*2*es + 2*es - 1]   = 1'b1;
                end
                issue(ta, tb, 2'(sz), u[0], 1'b0, 1'b0);
                chk({size_req(sz), " R4 top bit"}, result, model(ta, tb, sz, u[0]));
            end
        end

        // R4 directed literals
        issue('0, 64'h80, 2'd0, 1'b0, 1'b0, 1'b0);
        chk("R4 signed 8", result, 128'hFF80);
        issue('0, 64'h80, 2'd0, 1'b1, 1'b0, 1'b0);
        chk("R4 unsigned 8", result, 128'h0080);
        // R2 signed minus one
        issue(128'h5, 64'hFFFF, 2'd1, 1'b0, 1'b0, 1'b0);
        chk("R2 signed 16", result, 128'h4);
        // R5 wrap without carry into lane 1
        issue(128'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd2, 1'b1, 1'b0, 1'b0);
        chk("R5 no carry", result, '0);
        chk("R8 valid after wrap", out_valid, 1'b1);

        // R10 idle: result holds, valid drops
        issue(128'h1234, 64'h1, 2'd0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk("R10 idle valid", {out_valid, reserved_flag, undef_flag}, 3'b000);
        chk("R10 idle hold", result, 128'h1235);

        // R6 reserved size
        issue('1, '1, 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R6 flags", {out_valid, reserved_flag, undef_flag}, 3'b010);
        chk("R6 result", result, '0);

        // R7 undefined via destination and source index
        issue(128'h99, 64'h1, 2'd0, 1'b1, 1'b0, 1'b0);
        issue(128'h99, 64'h1, 2'd0, 1'b1, 1'b1, 1'b0);
        chk("R7 dst flags", {out_valid, reserved_flag, undef_flag}, 3'b001);
        chk("R7 dst result", result, '0);
        issue(128'h99, 64'h1, 2'd1, 1'b1, 1'b0, 1'b1);
        chk("R7 src flags", {out_valid, reserved_flag, undef_flag}, 3'b001);
        chk("R7 src result", result, '0);

        // R9 reset wins over an accepted operation
        issue(128'h77, 64'h1, 2'd0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        chk("R9 mid reset", {out_valid, reserved_flag, undef_flag}, 3'b000);
        chk("R9 mid reset result", result, '0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule